// File: doc/BRIEF.md
# Last-Target Indirect Branch Predictor

This block predicts where an indirect jump will land by remembering, for each slot of a direct-mapped table, the last destination that a jump mapping to that slot went to. The slot is chosen from a window of low instruction-address bits, after the bits that instruction alignment forces to zero have been shifted out. No tag and no valid bit are kept, so two jumps that share a slot share one remembered destination. The table starts out all zero, and zero is the cold prediction.

A caller presents a branch address together with the destination it actually resolved to. One cycle later the block returns the remembered destination and a mispredict flag, which is set when the remembered value differs from the resolved one. The slot is then always replaced by the resolved destination, whether the prediction was right or wrong. Reset clears the table one slot per cycle. The block holds `ready` low until every slot has been cleared and ignores requests during that time.

Top module: `ibp_last_target`

## Requirements
- R1: The slot index is bits [ALIGN_SH +: IDX_W] of `req_pc`. With the defaults this is `req_pc[10:2]`. Address bits below and above that window do not affect which slot is used, so addresses that agree in the window alias to one slot.
- R2: In the cycle after a request is accepted (`req_valid` and `ready` both high at a rising edge), `rsp_pred` holds the destination that was stored in the indexed slot.
- R3: When `rsp_valid` is high, `rsp_miss` is 1 exactly when `rsp_pred` differs from the `req_target` of the accepted request. It is 0 when they are equal.
- R4: Every accepted request writes its `req_target` into the indexed slot. This happens even when the prediction was correct and even when the target is zero.
- R5: The lookup reads the slot before the same request's write lands. A request to the same slot in the very next cycle sees the value just written.
- R6: `rsp_valid` is 1 in the cycle after an accepted request and 0 in every other cycle.
- R7: Reset is synchronous and active high. While `rst` is high, and for the first 2^IDX_W cycles after it falls, `ready` is 0. After that many cycles `ready` is 1 and stays 1 until the next reset.
- R8: A request made while `ready` is 0 is ignored. No response follows, and the table is not written.
- R9: After the clearing sweep, every slot reads as zero. This holds even after a reset in the middle of operation, when slots held nonzero values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; starts the clearing sweep |
| req_valid | input | 1 | A lookup/update request is present |
| req_pc | input | ADDR_W | Address of the indirect branch |
| req_target | input | ADDR_W | Destination the branch actually resolved to |
| ready | output | 1 | High when requests are accepted (sweep finished) |
| rsp_valid | output | 1 | Response for the request accepted in the previous cycle |
| rsp_pred | output | ADDR_W | Destination stored in the slot before the update |
| rsp_miss | output | 1 | Stored destination differed from the resolved one |

## Verification
Two things can fall in the same cycle: the read of a slot by one request and the write of that slot by the request just before it. The read and the write of a single request also fall in the same cycle. The bench provokes both by sending back-to-back requests to one slot with changing destinations. It expects each response to carry the value left by the immediately preceding request and never the value of its own. A second collision, between the clearing sweep and a late request, is provoked by issuing a request on the last sweep cycle. The bench judges it by the missing response and by a zero prediction for that slot afterwards.

// File: rtl/ibp_pkg.sv
package ibp_pkg;

    typedef enum logic {
        SW_CLEAR = 1'b0,
        SW_RUN   = 1'b1
    } sweep_state_t;

    typedef enum logic [1:0] {
        WS_NONE  = 2'd0,
        WS_CLEAR = 2'd1,
        WS_REQ   = 2'd2
    } wr_src_t;

endpackage

// File: rtl/ibp_index.sv
module ibp_index #(
    parameter int ADDR_W   = 32,
    parameter int IDX_W    = 9,
    parameter int ALIGN_SH = 2
) (
    input  logic [ADDR_W-1:0] pc,
    output logic [IDX_W-1:0]  idx
);
    logic [ADDR_W-1:0] shifted;

    always_comb begin
        shifted = pc >> ALIGN_SH;
        idx     = shifted[IDX_W-1:0];
    end

    // R1: the window must fit inside the address
    initial begin
        assert (ALIGN_SH + IDX_W <= ADDR_W)
            else $error("index window exceeds address width");
    end
endmodule

// File: rtl/ibp_sweep.sv
module ibp_sweep
    import ibp_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    output logic             busy,
    output logic [IDX_W-1:0] clr_idx
);
    localparam logic [IDX_W-1:0] LAST = '1;

    sweep_state_t     st;
    logic [IDX_W-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SW_CLEAR;
            ptr <= '0;
        end else if (st == SW_CLEAR) begin
            ptr <= ptr + 1'b1;
            if (ptr == LAST) st <= SW_RUN;
        end
    end

    always_comb begin
        busy    = (st == SW_CLEAR);
        clr_idx = ptr;
    end

    p_run_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (st == SW_RUN) |=> (st == SW_RUN));

    p_ptr_advance_r7: assert property (@(posedge clk) disable iff (rst)
        (st == SW_CLEAR) |=> (ptr == $past(ptr) + 1'b1));
endmodule

// File: rtl/ibp_table.sv
module ibp_table #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [ADDR_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    always_comb rd_data = mem[rd_idx];

    p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mem[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/ibp_last_target.sv
module ibp_last_target
    import ibp_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int IDX_W    = 9,
    parameter int ALIGN_SH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_pc,
    input  logic [ADDR_W-1:0] req_target,
    output logic              ready,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_pred,
    output logic              rsp_miss
);
    logic [IDX_W-1:0]  lk_idx;
    logic [IDX_W-1:0]  clr_idx;
    logic              busy;
    logic              accept;
    logic [ADDR_W-1:0] rd_data;
    wr_src_t           wsrc;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [ADDR_W-1:0] wr_data;

    ibp_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_SH(ALIGN_SH)) u_index (
        .pc  (req_pc),
        .idx (lk_idx)
    );

    ibp_sweep #(.IDX_W(IDX_W)) u_sweep (
        .clk     (clk),
        .rst     (rst),
        .busy    (busy),
        .clr_idx (clr_idx)
    );

    always_comb begin
        ready  = !busy;
        accept = req_valid && !busy;
        if (busy)        wsrc = WS_CLEAR;
        else if (accept) wsrc = WS_REQ;
        else             wsrc = WS_NONE;
        unique case (wsrc)
            WS_CLEAR: begin wr_en = 1'b1; wr_idx = clr_idx; wr_data = '0;         end
            WS_REQ:   begin wr_en = 1'b1; wr_idx = lk_idx;  wr_data = req_target; end
            default:  begin wr_en = 1'b0; wr_idx = lk_idx;  wr_data = req_target; end
        endcase
    end

    ibp_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (lk_idx),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data)
    );

    // read-before-write: rd_data is the slot value before this edge's write
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_pred  <= '0;
            rsp_miss  <= 1'b0;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_pred <= rd_data;
                rsp_miss <= (rd_data != req_target);
            end
        end
    end

    p_rsp_follows_accept_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ready) |=> rsp_valid);

    p_no_rsp_when_stalled_r8: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && ready) |=> !rsp_valid);

    p_miss_matches_target_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ready) |=> (rsp_miss == (rsp_pred != $past(req_target))));

    p_sweep_blocks_req_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (wr_data == '0));
endmodule

// File: tb/sim_ibp_last_target.sv
module sim_ibp_last_target;
    localparam int AW    = 16;
    localparam int IW    = 4;
    localparam int SH    = 2;
    localparam int DEPTH = 1 << IW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_pc = '0;
    logic [AW-1:0] req_target = '0;
    logic          ready;
    logic          rsp_valid;
    logic [AW-1:0] rsp_pred;
    logic          rsp_miss;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    logic [AW-1:0] model [DEPTH];
    bit            pend_v = 0;
    logic [AW-1:0] pend_pred = '0;
    bit            pend_miss = 0;
    string         pend_tag = "";

    always #5 clk = ~clk;

    ibp_last_target #(.ADDR_W(AW), .IDX_W(IW), .ALIGN_SH(SH)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_pc(req_pc),
        .req_target(req_target), .ready(ready), .rsp_valid(rsp_valid),
        .rsp_pred(rsp_pred), .rsp_miss(rsp_miss)
    );

    task automatic chk(input bit ok, input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int slot(input logic [AW-1:0] pc);
        return int'((pc >> SH) & (DEPTH - 1));
    endfunction

    // one cycle: judge the previous request's response, then drive a new one
    task automatic step(input bit v, input logic [AW-1:0] pc, input logic [AW-1:0] tgt,
                        input bit rdy, input string tag);
        @(negedge clk);
        chk(rsp_valid == pend_v, {pend_tag, " R6 valid"}, AW'(rsp_valid), AW'(pend_v));
        if (pend_v) begin
            chk(rsp_pred == pend_pred, {pend_tag, " R2 pred"}, rsp_pred, pend_pred);
            chk(rsp_miss == pend_miss, {pend_tag, " R3 miss"}, AW'(rsp_miss), AW'(pend_miss));
        end
        chk(ready == rdy, "R7 ready", AW'(ready), AW'(rdy));
        req_valid  = v;
        req_pc     = pc;
        req_target = tgt;
        pend_v     = v && rdy;
        pend_tag   = tag;
        if (pend_v) begin
            pend_pred = model[slot(pc)];
            pend_miss = (model[slot(pc)] != tgt);
            model[slot(pc)] = tgt;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        chk(ready == 1'b0, "R7 ready in reset", AW'(ready), '0);
        chk(rsp_valid == 1'b0, "R6 valid in reset", AW'(rsp_valid), '0);
        @(negedge clk);
        rst = 1'b0;
        pend_v = 0;
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        // sweep: ready stays low for DEPTH cycles; a late request is ignored (R8)
        for (int k = 1; k < DEPTH; k++)
            step(k == DEPTH - 1, AW'(3 << SH), 16'hBEEF, 1'b0, "R8 during sweep");
        step(1'b0, '0, '0, 1'b1, "R7 sweep end");
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        do_reset();

        // R9 / R8: slot 3 must read zero despite the ignored request
        step(1'b1, AW'(3 << SH), '0, 1'b1, "R8 R9 slot3 zero");

        // cold pass over every slot (R2 R3 R4), one target of zero
        for (int i = 0; i < DEPTH; i++)
            step(1'b1, AW'(i << SH), (i == 5) ? '0 : AW'(16'h1000 + i * 16'h0111), 1'b1, "R2 cold");
        // warm pass: same targets predicted, no miss (R4 even on match)
        for (int i = 0; i < DEPTH; i++)
            step(1'b1, AW'(i << SH), (i == 5) ? '0 : AW'(16'h1000 + i * 16'h0111), 1'b1, "R4 warm");
        // R5: back-to-back on one slot with changing targets
        step(1'b1, AW'(7 << SH), 16'hAAAA, 1'b1, "R5 b2b a");
        step(1'b1, AW'(7 << SH), 16'h5555, 1'b1, "R5 b2b b");
        step(1'b1, AW'(7 << SH), 16'h5555, 1'b1, "R5 b2b c");
        step(1'b1, AW'(7 << SH), 16'h0000, 1'b1, "R5 b2b d");
        // R1: aliasing via high bits and low alignment bits
        step(1'b1, AW'((9 << SH) | (1 << (IW + SH))), 16'h1234, 1'b1, "R1 alias high");
        step(1'b1, AW'((9 << SH) | 3), 16'h4321, 1'b1, "R1 alias low");
        step(1'b1, AW'((9 << SH) | 16'hF000), 16'h4321, 1'b1, "R1 alias both");
        // R6: idle cycles produce no response
        step(1'b0, AW'(2 << SH), 16'h7777, 1'b1, "R6 idle");
        step(1'b0, '0, '0, 1'b1, "R6 idle");
        step(1'b1, AW'(2 << SH), 16'h7777, 1'b1, "R6 after idle");

        // R9: reset mid-run wipes the table
        do_reset();
        for (int i = 0; i < DEPTH; i++)
            step(1'b1, AW'(i << SH), '0, 1'b1, "R9 cleared");
        step(1'b0, '0, '0, 1'b1, "R9 drain");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule